// File: doc/BRIEF.md
# Dual-Mode Instruction Fetch Unit

This unit supplies instructions to a core that runs in one of two instruction-set states. In the full state every instruction is a 32-bit word. In the compact state instructions are 16-bit halfwords, and some of them extend to 32 bits. The unit keeps two addresses: the address of the instruction now being presented, which is also exported as the program-counter value, and the address of the next fetch. For each fetch it sends one read request on a valid/ready memory port. The request is a word or a halfword, as chosen by the state bit sampled when the fetch starts. The returned data is latched and held for the decoder under a valid/ready handshake.

When the decoder finds that a compact instruction is the first half of a 32-bit one, it raises an extension request. The unit then reads the following halfword, presents both halves together and flags the instruction as wide. A redirect input loads a new fetch address at any time. It drops the presented instruction, and any response still owed to a cancelled request is thrown away. A fetch address that is not aligned to its access size stops the unit with a fault output until the next redirect.

Top module: `dual_isa_fetch`

## Requirements
- R1: During and right after reset, no memory request and no instruction are valid, the exported program counter is 0, the fault output is low, and the first fetch is a word read at address 0.
- R2: With the state input low when a fetch starts, the unit issues a word read (`mem_req_word_o` = 1) at the fetch address, presents all 32 returned bits, and the following fetch address is 4 higher.
- R3: With the state input high when a fetch starts, the unit issues a halfword read (`mem_req_word_o` = 0), presents the low 16 returned bits zero-extended to 32, and the following fetch address is 2 higher.
- R4: `pc_o` equals the address of the fetch that is in progress or being presented. It takes the new value when each fetch starts.
- R5: A fetch address with bit 0 set in compact mode, or with either of bits 1:0 set in full mode, raises `align_fault_o`. While the fault is high no request is issued, and the fault stays until a redirect.
- R6: Every request carries the access-kind code 4 (instruction fetch) on `mem_req_kind_o`. The codes for debug read, debug write, data read and data write are 0 to 3.
- R7: In compact mode, `ext_req_i` raised while an instruction is presented causes a halfword read at the instruction address plus 2. The low 16 bits of that response appear on `insn_ext_o`, `insn_wide_o` goes high, and the following fetch address becomes the instruction address plus 4.
- R8: `ext_req_i` has no effect on an instruction fetched in full mode. No request is issued, `insn_wide_o` stays low, and the next fetch still starts 4 bytes on.
- R9: A redirect drops `insn_valid_o` on the next cycle and makes the next fetch use the redirect address. A response owed to a request that was in flight is discarded and never presented.
- R10: `insn_valid_o` and the presented instruction stay unchanged until `insn_ready_i` is seen. A memory request holds its valid, address and size until `mem_req_ready_i` is seen.
- R11: The state input is sampled only when a fetch starts. Changing it while an instruction is presented does not change `insn_compact_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| compact_mode_i | input | 1 | Instruction-set state: 1 = 16-bit compact, 0 = 32-bit |
| redirect_valid_i | input | 1 | Load a new fetch address |
| redirect_addr_i | input | AW | New fetch address |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | AW | Request byte address |
| mem_req_word_o | output | 1 | 1 = word read, 0 = halfword read |
| mem_req_kind_o | output | 3 | Access-kind code, 4 for fetch |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DW | Read data |
| insn_valid_o | output | 1 | Instruction presented |
| insn_ready_i | input | 1 | Decoder takes the instruction |
| ext_req_i | input | 1 | Decoder asks for the second halfword |
| insn_o | output | DW | Instruction, or first halfword zero-extended |
| insn_ext_o | output | DW/2 | Second halfword of a wide compact instruction |
| insn_wide_o | output | 1 | Second halfword is valid |
| insn_compact_o | output | 1 | Instruction was fetched in compact mode |
| pc_o | output | AW | Current instruction address |
| align_fault_o | output | 1 | Misaligned fetch address |

## Verification
The main stream walks a sequence of full-mode fetches, plain compact fetches and extended compact fetches, switching mode at several points. Each step checks the address, access size and returned data, so a wrong step of 2 against 4, or a wrong data slice, shows up as a wrong next address or wrong instruction bits. An extension request in full mode shows whether the request is gated by mode. A redirect while a slow response is still owed shows whether stale data is discarded or wrongly presented at the new address. Misaligned targets in both modes, a mode change while an instruction is held, and a memory that withholds ready check the fault, the sampling point of the state bit, and the request hold.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [2:0] {
        ACC_DBG_RD  = 3'd0,
        ACC_DBG_WR  = 3'd1,
        ACC_DATA_RD = 3'd2,
        ACC_DATA_WR = 3'd3,
        ACC_FETCH   = 3'd4
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_REQ,
        ST_WAIT,
        ST_HOLD,
        ST_XREQ,
        ST_XWAIT,
        ST_FAULT
    } fetch_st_e;

endpackage

// File: rtl/fetch_addr_step.sv
module fetch_addr_step #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          half_i,
    output logic [AW-1:0] addr_o
);
    localparam int WORD_BYTES = DW / 8;
    localparam int HALF_BYTES = DW / 16;
    localparam logic [AW-1:0] WORD_INC = AW'(WORD_BYTES);
    localparam logic [AW-1:0] HALF_INC = AW'(HALF_BYTES);

    always_comb begin
        addr_o = addr_i + (half_i ? HALF_INC : WORD_INC);
    end
endmodule

// File: rtl/fetch_align_chk.sv
module fetch_align_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          half_i,
    output logic          misaligned_o
);
    localparam int WORD_LSB = $clog2(DW / 8);
    localparam int HALF_LSB = $clog2(DW / 16);

    logic word_bad;
    logic half_bad;

    generate
        if (HALF_LSB > 0) begin : g_half
            assign half_bad = |addr_i[HALF_LSB-1:0];
        end else begin : g_half_none
            assign half_bad = 1'b0;
        end
    endgenerate

    assign word_bad     = |addr_i[WORD_LSB-1:0];
    assign misaligned_o = half_i ? half_bad : word_bad;
endmodule

// File: rtl/dual_isa_fetch.sv
module dual_isa_fetch
    import fetch_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            compact_mode_i,
    input  logic            redirect_valid_i,
    input  logic [AW-1:0]   redirect_addr_i,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [AW-1:0]   mem_req_addr_o,
    output logic            mem_req_word_o,
    output logic [2:0]      mem_req_kind_o,
    input  logic            mem_rsp_valid_i,
    input  logic [DW-1:0]   mem_rsp_data_i,
    output logic            insn_valid_o,
    input  logic            insn_ready_i,
    input  logic            ext_req_i,
    output logic [DW-1:0]   insn_o,
    output logic [DW/2-1:0] insn_ext_o,
    output logic            insn_wide_o,
    output logic            insn_compact_o,
    output logic [AW-1:0]   pc_o,
    output logic            align_fault_o
);
    localparam int HW = DW / 2;
    localparam int DROP_W = 2;

    typedef struct packed {
        fetch_st_e         st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     nxt;
        logic              compact;
        logic [DW-1:0]     insn;
        logic [HW-1:0]     ext;
        logic              wide;
        logic [DROP_W-1:0] drop;
    } fetch_state_t;

    fetch_state_t s_q, s_d;

    logic [AW-1:0] nxt_inc;
    logic [AW-1:0] cur_plus_half;
    logic [AW-1:0] cur_plus_word;
    logic          nxt_misaligned;
    logic          rsp_take;
    logic          own_pending;

    fetch_addr_step #(.AW(AW), .DW(DW)) u_step_next (
        .addr_i (s_q.nxt),
        .half_i (compact_mode_i),
        .addr_o (nxt_inc)
    );

    fetch_addr_step #(.AW(AW), .DW(DW)) u_step_half (
        .addr_i (s_q.cur),
        .half_i (1'b1),
        .addr_o (cur_plus_half)
    );

    fetch_addr_step #(.AW(AW), .DW(DW)) u_step_word (
        .addr_i (s_q.cur),
        .half_i (1'b0),
        .addr_o (cur_plus_word)
    );

    fetch_align_chk #(.AW(AW), .DW(DW)) u_align (
        .addr_i       (s_q.nxt),
        .half_i       (compact_mode_i),
        .misaligned_o (nxt_misaligned)
    );

    // A response is ours only when no cancelled response is still owed.
    assign rsp_take = mem_rsp_valid_i && (s_q.drop == '0);

    always_comb begin
        own_pending = 1'b0;
        if ((s_q.st == ST_REQ) || (s_q.st == ST_XREQ)) begin
            own_pending = mem_req_ready_i;
        end else if ((s_q.st == ST_WAIT) || (s_q.st == ST_XWAIT)) begin
            own_pending = !rsp_take;
        end
    end

    always_comb begin
        s_d = s_q;

        if (mem_rsp_valid_i && (s_q.drop != '0)) begin
            s_d.drop = s_q.drop - 1'b1;
        end

        unique case (s_q.st)
            ST_START: begin
                s_d.cur     = s_q.nxt;
                s_d.compact = compact_mode_i;
                s_d.wide    = 1'b0;
                if (nxt_misaligned) begin
                    s_d.st = ST_FAULT;
                end else begin
                    s_d.nxt = nxt_inc;
                    s_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_take) begin
                    s_d.insn = s_q.compact ? {{HW{1'b0}}, mem_rsp_data_i[HW-1:0]}
                                           : mem_rsp_data_i;
                    s_d.ext  = '0;
                    s_d.st   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (insn_ready_i) begin
                    s_d.st = ST_START;
                end else if (ext_req_i && s_q.compact && !s_q.wide) begin
                    s_d.st = ST_XREQ;
                end
            end
            ST_XREQ: begin
                if (mem_req_ready_i) s_d.st = ST_XWAIT;
            end
            ST_XWAIT: begin
                if (rsp_take) begin
                    s_d.ext  = mem_rsp_data_i[HW-1:0];
                    s_d.wide = 1'b1;
                    s_d.nxt  = cur_plus_word;
                    s_d.st   = ST_HOLD;
                end
            end
            ST_FAULT: begin
                s_d.st = ST_FAULT;
            end
            default: begin
                s_d.st = ST_START;
            end
        endcase

        if (redirect_valid_i) begin
            s_d.nxt  = redirect_addr_i;
            s_d.st   = ST_START;
            s_d.wide = 1'b0;
            if (own_pending) s_d.drop = s_d.drop + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_START;
            s_q.cur     <= '0;
            s_q.nxt     <= '0;
            s_q.compact <= 1'b0;
            s_q.insn    <= '0;
            s_q.ext     <= '0;
            s_q.wide    <= 1'b0;
            s_q.drop    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_valid_o = (s_q.st == ST_REQ) || (s_q.st == ST_XREQ);
    assign mem_req_addr_o  = (s_q.st == ST_XREQ) ? cur_plus_half : s_q.cur;
    assign mem_req_word_o  = (s_q.st == ST_REQ) && !s_q.compact;
    assign mem_req_kind_o  = 3'(ACC_FETCH);
    assign insn_valid_o    = (s_q.st == ST_HOLD);
    assign insn_o          = s_q.insn;
    assign insn_ext_o      = s_q.ext;
    assign insn_wide_o     = s_q.wide;
    assign insn_compact_o  = s_q.compact;
    assign pc_o            = s_q.cur;
    assign align_fault_o   = (s_q.st == ST_FAULT);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i && !redirect_valid_i
        |=> mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_word_o)); // R10

    AST_INSN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && !insn_ready_i && !redirect_valid_i && !ext_req_i
        |=> insn_valid_o && $stable(insn_o)); // R10

    AST_FETCH_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> mem_req_kind_o == 3'd4); // R6

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> !mem_req_valid_o); // R5

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !mem_req_addr_o[0] && (!mem_req_word_o || !mem_req_addr_o[1])); // R5

    AST_WIDE_ONLY_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && insn_wide_o |-> insn_compact_o); // R8

    AST_REDIRECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_i |=> !insn_valid_o && !mem_req_valid_o); // R9

    AST_COMPACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && !insn_ready_i && !redirect_valid_i |=> $stable(insn_compact_o)); // R11
endmodule

// File: tb/tb_dual_isa_fetch.sv
`timescale 1ns/1ps
module tb_dual_isa_fetch;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int HW = DW / 2;
    localparam int NV = 9;
    // {compact, ext request, address}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 16'h0004}, {1'b1, 1'b0, 16'h0008},
        {1'b1, 1'b1, 16'h000A}, {1'b1, 1'b0, 16'h000E}, {1'b1, 1'b1, 16'h0010},
        {1'b1, 1'b1, 16'h0014}, {1'b0, 1'b0, 16'h0018}, {1'b0, 1'b1, 16'h001C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic compact_mode_i = 1'b0;
    logic redirect_valid_i = 1'b0;
    logic [AW-1:0] redirect_addr_i = '0;
    logic mem_req_valid_o, mem_req_ready_i, mem_req_word_o;
    logic [AW-1:0] mem_req_addr_o;
    logic [2:0] mem_req_kind_o;
    logic mem_rsp_valid_i = 1'b0;
    logic [DW-1:0] mem_rsp_data_i = '0;
    logic insn_valid_o, insn_wide_o, insn_compact_o, align_fault_o;
    logic insn_ready_i = 1'b0;
    logic ext_req_i = 1'b0;
    logic [DW-1:0] insn_o;
    logic [HW-1:0] insn_ext_o;
    logic [AW-1:0] pc_o;

    int checks = 0;
    int fails = 0;

    // memory model state
    bit busy = 0;
    bit hold = 0;
    int wait_n = 0;
    int lat = 0;
    logic [AW-1:0] cap_addr = '0;
    bit cap_word = 0;
    logic [AW-1:0] last_addr = '0;
    bit last_word = 0;
    logic [2:0] last_kind = '0;
    int req_count = 0;

    always #4 clk = ~clk;

    dual_isa_fetch #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .compact_mode_i(compact_mode_i),
        .redirect_valid_i(redirect_valid_i), .redirect_addr_i(redirect_addr_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_req_word_o(mem_req_word_o),
        .mem_req_kind_o(mem_req_kind_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .insn_valid_o(insn_valid_o),
        .insn_ready_i(insn_ready_i), .ext_req_i(ext_req_i), .insn_o(insn_o),
        .insn_ext_o(insn_ext_o), .insn_wide_o(insn_wide_o),
        .insn_compact_o(insn_compact_o), .pc_o(pc_o), .align_fault_o(align_fault_o)
    );

    function automatic logic [DW-1:0] mem_data(logic [AW-1:0] a, bit word);
        return word ? {~a[15:0], a[15:0]} : {16'hDEAD, a[15:0] ^ 16'h5A5A};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial mem_req_ready_i = 1'b1;
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (busy) begin
                if (wait_n == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = mem_data(cap_addr, cap_word);
                    busy = 0;
                end else begin
                    wait_n--;
                end
            end
            mem_req_ready_i = !busy && !hold;
            if (mem_req_valid_o && mem_req_ready_i && rst_n) begin
                busy = 1; wait_n = lat;
                cap_addr = mem_req_addr_o; cap_word = mem_req_word_o;
                last_addr = mem_req_addr_o; last_word = mem_req_word_o;
                last_kind = mem_req_kind_o;
                req_count++;
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_valid(input string tag);
        for (int k = 0; k < 60 && !insn_valid_o; k++) step();
        chk(insn_valid_o, tag, AW'(insn_valid_o), 1);
    endtask

    task automatic get_insn(input logic [AW-1:0] a, input bit cmp, input bit ext,
                            input bit accept);
        logic [DW-1:0] exp_insn;
        int rc;
        wait_valid("R2/R3 valid");
        exp_insn = cmp ? {16'h0, a[15:0] ^ 16'h5A5A} : mem_data(a, 1'b1);
        chk(pc_o == a, "R4 pc", pc_o, a);
        chk(insn_o == exp_insn, cmp ? "R3 data" : "R2 data", insn_o, exp_insn);
        chk(last_addr == a && last_word == !cmp, cmp ? "R3 size" : "R2 size",
            {last_addr[30:0], last_word}, {a[30:0], !cmp});
        chk(last_kind == 3'd4, "R6 kind", AW'(last_kind), 4);
        chk(insn_compact_o == cmp, "R11 mode", AW'(insn_compact_o), AW'(cmp));
        // R10: held while not accepted
        step(); step();
        chk(insn_valid_o && insn_o == exp_insn, "R10 hold", insn_o, exp_insn);
        if (ext) begin
            rc = req_count;
            ext_req_i = 1'b1; step(); ext_req_i = 1'b0;
            if (cmp) begin
                step();
                wait_valid("R7 valid");
                chk(insn_wide_o, "R7 wide", AW'(insn_wide_o), 1);
                chk(insn_ext_o == ((a[15:0] + 16'd2) ^ 16'h5A5A), "R7 ext",
                    AW'(insn_ext_o), AW'((a[15:0] + 16'd2) ^ 16'h5A5A));
                chk(last_addr == a + 2 && !last_word, "R7 req", last_addr, a + 2);
                chk(insn_o == exp_insn, "R7 first half", insn_o, exp_insn);
            end else begin
                step(); step();
                chk(insn_valid_o && !insn_wide_o && req_count == rc, "R8 ignored",
                    AW'(req_count - rc), 0);
            end
        end
        if (accept) begin
            insn_ready_i = 1'b1; step(); insn_ready_i = 1'b0;
        end
    endtask

    task automatic redirect(input logic [AW-1:0] a);
        redirect_addr_i = a; redirect_valid_i = 1'b1; step(); redirect_valid_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        chk(!mem_req_valid_o && !insn_valid_o && pc_o == 0 && !align_fault_o, "R1 reset",
            {pc_o[28:0], mem_req_valid_o, insn_valid_o, align_fault_o}, 0);
        rst_n = 1'b1;
        step(); step();
        chk(mem_req_valid_o == 0 || (mem_req_addr_o == 0 && mem_req_word_o), "R1 first",
            mem_req_addr_o, 0);

        for (int i = 0; i < NV; i++) begin
            get_insn(AW'(VEC[i][15:0]), VEC[i][17], VEC[i][16], 1'b0);
            if (i < NV - 1) compact_mode_i = VEC[i+1][17];
            insn_ready_i = 1'b1; step(); insn_ready_i = 1'b0;
        end

        // R8: ignored extension in full mode leaves the step at 4
        get_insn(32'h20, 1'b0, 1'b0, 1'b0);
        redirect(32'h40);
        chk(!insn_valid_o, "R9 drop valid", AW'(insn_valid_o), 0);
        get_insn(32'h40, 1'b0, 1'b0, 1'b1);

        // R9: redirect while a slow response is owed
        lat = 3;
        for (int k = 0; k < 20 && !(busy && wait_n > 0); k++) step();
        lat = 0;
        redirect(32'h80);
        get_insn(32'h80, 1'b0, 1'b0, 1'b1);

        // R5: misaligned word and halfword targets
        compact_mode_i = 1'b0;
        redirect(32'h102);
        step(); step();
        chk(align_fault_o && !mem_req_valid_o, "R5 word fault", AW'(align_fault_o), 1);
        chk(pc_o == 32'h102, "R4 fault pc", pc_o, 32'h102);
        step(); step();
        chk(align_fault_o, "R5 fault held", AW'(align_fault_o), 1);
        compact_mode_i = 1'b1;
        redirect(32'h101);
        step(); step();
        chk(align_fault_o && !mem_req_valid_o, "R5 half fault", AW'(align_fault_o), 1);
        redirect(32'h102);
        step();
        chk(!align_fault_o, "R5 clear", AW'(align_fault_o), 0);
        get_insn(32'h102, 1'b1, 1'b0, 1'b0);

        // R11: mode change while held does not alter presented mode
        compact_mode_i = 1'b0;
        step();
        chk(insn_compact_o, "R11 held mode", AW'(insn_compact_o), 1);
        hold = 1'b1;
        insn_ready_i = 1'b1; step(); insn_ready_i = 1'b0;
        step(); step(); step();
        chk(mem_req_valid_o && mem_req_addr_o == 32'h104 && mem_req_word_o, "R10 req hold",
            mem_req_addr_o, 32'h104);
        hold = 1'b0;
        get_insn(32'h104, 1'b0, 1'b0, 1'b1);
        get_insn(32'h108, 1'b0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule